// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A synthesizable behavioural model of a synchronous static RAM whose read path has no output register. The word is four byte lanes of nine bits each, 36 bits in all. The depth is set by a parameter. On the rising clock edge the block captures the address, the write data, the three chip selects, the lane and global write controls, and the two load strobes. The word at the captured address then flows from the array to the output in the cycle that follows that edge.

Two load strobes start an access. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. When neither strobe is active, the step input either moves the access to the next address of a four-word burst or holds it on the current address. The burst order is wrapping linear or interleaved, chosen by a static input.

A sleep input freezes the block and turns off the outputs, and the array keeps its contents. The bidirectional data bus is split into a data input, a data output and an output-valid flag.

Top module: `ftburst_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released until the next load strobe, `q_oe` is 0, `q_out` is 0 and the device is deselected. Array contents are not cleared.
- R2: With `strobe_p_n` low and `cs_main_n` low, the external address is loaded and a read is performed, even if write controls are asserted. With `cs_main_n` high, `strobe_p_n` is ignored.
- R3: With `strobe_c_n` low, `strobe_p_n` not taking effect and `cs_main_n` low, the external address is loaded and a read or a write is performed. With `cs_main_n` high, this strobe deselects the device, and `q_oe` stays 0.
- R4: A write is decoded in two cases. With `wr_all_n` low, all four lanes are written. With `wr_lane_n` low, only the lanes whose `lane_n[i]` bit is low are written, and lane i is `d_in[9i+8:9i]`. With `wr_lane_n` low and every bit of `lane_n` high, the cycle is a read.
- R5: `cs_hi` and `cs_lo_n` are sampled only on a load edge. If `cs_hi` is low or `cs_lo_n` is high there, the device is deselected. On continue and hold edges, all three selects are ignored.
- R6: With no strobe taking effect and `step_n` low, the two low address bits advance through a four-word burst and the upper bits are kept. With `burst_ilv`=0 the k-th word is at base+k mod 4. With `burst_ilv`=1 it is at base XOR k. Reads and writes both advance.
- R7: With no strobe taking effect and `step_n` high, the address is held, for reads and for writes.
- R8: A write to the address just loaded by `strobe_p_n` is made on the next edge, with `step_n` high and the write controls asserted there.
- R9: While `sleep` is high, `q_oe` is 0 at once, every other input is ignored, and the address, select state and array contents are kept.
- R10: `q_oe` is 1 only when `out_en_n` is low, the device is selected and the current cycle is a read. `q_out` then holds the array word at the current address, in the cycle after the capturing edge. Otherwise `q_out` is 0.
- R11: In a write cycle `q_oe` is 0 whatever `out_en_n` is. After a write, a hold cycle with no write keeps `q_oe` at 0 until a strobe or step cycle.
- R12: A word written at an address is returned by the next read of that address, merged lane by lane with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Asynchronous freeze, active high |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | External word address |
| d_in | input | 36 | Write data, four 9-bit lanes |
| cs_main_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| strobe_p_n | input | 1 | Processor-side load strobe (read only) |
| strobe_c_n | input | 1 | Controller-side load strobe |
| step_n | input | 1 | Burst step (low) or hold (high) |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_n | input | 1 | Enable per-lane writes, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| q_out | output | 36 | Read data |
| q_oe | output | 1 | Read data valid and driven |

## Verification
The bench builds the block with its default parameters: a 6-bit address, four 9-bit lanes and a four-word burst. A 64-word array is small enough that every burst, including wraps in both orders and from non-zero base offsets, can be set up and read back with known data. Four seeded words plus one partial-lane rewrite are enough to show lane masking and burst ordering. The directed tail covers the asynchronous paths (sleep, output enable and reset) between clock edges.

// File: rtl/ftb_pkg.sv
`timescale 1ns/1ps
package ftb_pkg;
  // Kind of access started on a clock edge
  typedef enum logic [1:0] {
    CYC_LOAD_P = 2'd0,
    CYC_LOAD_C = 2'd1,
    CYC_DESEL  = 2'd2,
    CYC_CONT   = 2'd3
  } cyc_e;
endpackage

// File: rtl/ftb_burst.sv
`timescale 1ns/1ps
module ftb_burst #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-BURST_W-1:0] hi,
  input  logic [BURST_W-1:0]        base,
  input  logic [BURST_W-1:0]        cnt,
  input  logic                      ilv,
  output logic [ADDR_W-1:0]         addr
);
  logic [BURST_W-1:0] lo;

  always_comb begin
    if (ilv) lo = base ^ cnt;
    else     lo = base + cnt;
    addr = {hi, lo};
  end
endmodule

// File: rtl/ftb_array.sv
`timescale 1ns/1ps
module ftb_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [LANES-1:0]          wlanes,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlanes[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/ftb_ctrl.sv
`timescale 1ns/1ps
module ftb_ctrl
  import ftb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_main_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_n,
  input  logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_lanes,
  output logic              rd_act,
  output logic              wr_act
);
  localparam int HI_W = ADDR_W - BURST_W;

  cyc_e               cyc;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [BURST_W-1:0] base_q, base_d, cnt_q, cnt_d;
  logic               sel_q, sel_d, rd_q, rd_d, wr_q, wr_d;
  logic               wr_req, is_wr, fresh, clk_en;

  assign clk_en = !sleep;

  // Cycle decode and next state
  always_comb begin
    wr_req   = !wr_all_n || (!wr_lane_n && !(&lane_n));
    wr_lanes = !wr_all_n ? {LANES{1'b1}} : (!wr_lane_n ? ~lane_n : '0);

    if (!strobe_p_n && !cs_main_n) cyc = CYC_LOAD_P;
    else if (!strobe_c_n)          cyc = cs_main_n ? CYC_DESEL : CYC_LOAD_C;
    else                           cyc = CYC_CONT;

    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    is_wr  = 1'b0;
    fresh  = 1'b0;
    unique case (cyc)
      CYC_LOAD_P, CYC_LOAD_C: begin
        hi_d   = addr[ADDR_W-1:BURST_W];
        base_d = addr[BURST_W-1:0];
        cnt_d  = '0;
        sel_d  = cs_hi && !cs_lo_n;
        is_wr  = (cyc == CYC_LOAD_C) && wr_req;
        fresh  = 1'b1;
      end
      CYC_DESEL: sel_d = 1'b0;
      default: begin
        if (sel_q && !step_n) cnt_d = cnt_q + 1'b1;
        is_wr = wr_req;
        fresh = !step_n;
      end
    endcase

    wr_d = sel_d && is_wr;
    rd_d = sel_d && !is_wr && (fresh || rd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (clk_en) begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
    end
  end

  ftb_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cur (
    .hi(hi_q), .base(base_q), .cnt(cnt_q), .ilv(burst_ilv), .addr(cur_addr)
  );

  ftb_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_nxt (
    .hi(hi_d), .base(base_d), .cnt(cnt_d), .ilv(burst_ilv), .addr(wr_addr)
  );

  assign wr_en  = clk_en && wr_d;
  assign rd_act = rd_q;
  assign wr_act = wr_q;

  AST_PSTROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe_p_n && !cs_main_n) |=> !wr_act); // R2
  AST_CSTROBE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_p_n && !strobe_c_n && cs_main_n) |=> !sel_q); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_c_n && (strobe_p_n || cs_main_n) && !step_n && sel_q)
      |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1))); // R6
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_c_n && (strobe_p_n || cs_main_n) && step_n)
      |=> $stable(cur_addr)); // R7
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cur_addr) && $stable(sel_q) && $stable(rd_act))); // R9
endmodule

// File: rtl/ftburst_sram.sv
`timescale 1ns/1ps
module ftburst_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep,
  input  logic                     burst_ilv,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  d_in,
  input  logic                     cs_main_n,
  input  logic                     cs_hi,
  input  logic                     cs_lo_n,
  input  logic                     strobe_p_n,
  input  logic                     strobe_c_n,
  input  logic                     step_n,
  input  logic                     wr_all_n,
  input  logic                     wr_lane_n,
  input  logic [LANES-1:0]         lane_n,
  input  logic                     out_en_n,
  output logic [LANES*LANE_W-1:0]  q_out,
  output logic                     q_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic              wr_en, rd_act, wr_act;
  logic [LANES-1:0]  wr_lanes;
  logic [DATA_W-1:0] rdata;

  ftb_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .burst_ilv(burst_ilv),
    .addr(addr), .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_n(lane_n),
    .cur_addr(cur_addr), .wr_addr(wr_addr), .wr_en(wr_en),
    .wr_lanes(wr_lanes), .rd_act(rd_act), .wr_act(wr_act)
  );

  ftb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(wr_en), .wlanes(wr_lanes), .waddr(wr_addr),
    .wdata(d_in), .raddr(cur_addr), .rdata(rdata)
  );

  // Flow-through output: no register between array and pins
  always_comb begin
    q_oe  = !sleep && !out_en_n && rd_act;
    q_out = q_oe ? rdata : '0;
  end

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> !q_oe); // R11
endmodule

// File: tb/sim_ftburst_sram.sv
`timescale 1ns/1ps
module sim_ftburst_sram;
  localparam int AW = 6;
  localparam logic [35:0] A0 = 36'h123456789, A1 = 36'h2468ACE13,
                          A2 = 36'h0FEDCBA98, A3 = 36'h3C3C3C3C3,
                          B0 = 36'hABCDEF012, M0 = 36'h127FD67FF,
                          FF = 36'hFFFFFFFFF, ZZ = 36'h0;

  typedef struct packed {
    logic [31:0] tag;
    logic sp, sc, stp, ea, eb, ec, ga, gl;
    logic [3:0] ln;
    logic ilv;
    logic [5:0] a;
    logic [35:0] d;
    logic xoe;
    logic [35:0] xq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    '{"R4",  1,0,1,0,1,0,0,1,4'hF,0,6'd4,A0,0,ZZ},
    '{"R6",  1,1,0,0,1,0,0,1,4'hF,0,6'd0,A1,0,ZZ},
    '{"R6",  1,1,0,0,1,0,0,1,4'hF,0,6'd0,A2,0,ZZ},
    '{"R6",  1,1,0,0,1,0,0,1,4'hF,0,6'd0,A3,0,ZZ},
    '{"R2",  0,1,1,0,1,0,0,1,4'hF,0,6'd4,FF,1,A0},
    '{"R10", 1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A1},
    '{"R7",  1,1,1,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A1},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A2},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A3},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A0},
    '{"R6",  0,1,1,0,1,0,1,1,4'hF,1,6'd6,ZZ,1,A2},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,1,6'd0,ZZ,1,A3},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,1,6'd0,ZZ,1,A0},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,1,6'd0,ZZ,1,A1},
    '{"R6",  0,1,1,0,1,0,1,1,4'hF,0,6'd6,ZZ,1,A2},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A3},
    '{"R6",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A0},
    '{"R4",  1,0,1,0,1,0,1,0,4'hA,0,6'd4,FF,0,ZZ},
    '{"R12", 1,0,1,0,1,0,1,1,4'hF,0,6'd4,ZZ,1,M0},
    '{"R4",  1,0,1,0,1,0,1,0,4'hF,0,6'd5,FF,1,A1},
    '{"R5",  1,0,1,0,0,0,1,1,4'hF,0,6'd5,ZZ,0,ZZ},
    '{"R5",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,0,ZZ},
    '{"R2",  0,1,1,0,1,0,1,1,4'hF,0,6'd6,ZZ,1,A2},
    '{"R5",  1,1,0,1,0,1,1,1,4'hF,0,6'd0,ZZ,1,A3},
    '{"R3",  1,0,1,1,1,0,1,1,4'hF,0,6'd4,ZZ,0,ZZ},
    '{"R3",  1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,0,ZZ},
    '{"R2",  0,1,1,0,1,0,1,1,4'hF,0,6'd4,ZZ,1,M0},
    '{"R2",  0,1,1,1,1,0,1,1,4'hF,0,6'd7,ZZ,1,M0},
    '{"R8",  0,1,1,0,1,0,1,1,4'hF,0,6'd5,ZZ,1,A1},
    '{"R8",  1,1,1,0,1,0,0,1,4'hF,0,6'd0,B0,0,ZZ},
    '{"R11", 1,1,1,0,1,0,1,1,4'hF,0,6'd0,ZZ,0,ZZ},
    '{"R11", 1,1,0,0,1,0,1,1,4'hF,0,6'd0,ZZ,1,A2},
    '{"R12", 0,1,1,0,1,0,1,1,4'hF,0,6'd5,ZZ,1,B0}
  };

  logic clk = 1'b0, rst_n, sleep, burst_ilv;
  logic [AW-1:0] addr;
  logic [35:0] d_in, q_out;
  logic cs_main_n, cs_hi, cs_lo_n, strobe_p_n, strobe_c_n, step_n;
  logic wr_all_n, wr_lane_n, out_en_n, q_oe;
  logic [3:0] lane_n;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  ftburst_sram u0 (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .burst_ilv(burst_ilv),
    .addr(addr), .d_in(d_in), .cs_main_n(cs_main_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n),
    .lane_n(lane_n), .out_en_n(out_en_n), .q_out(q_out), .q_oe(q_oe)
  );

  task automatic check(input string tag, input logic xoe, input logic [35:0] xq);
    nchk++;
    if (q_oe !== xoe || q_out !== xq) begin
      nbad++;
      $display("FAIL %s: oe=%b q=%h expected oe=%b q=%h", tag, q_oe, q_out, xoe, xq);
    end
  endtask

  task automatic idle();
    strobe_p_n = 1; strobe_c_n = 1; step_n = 1; cs_main_n = 0; cs_hi = 1;
    cs_lo_n = 0; wr_all_n = 1; wr_lane_n = 1; lane_n = 4'hF; addr = '0; d_in = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    nchk++; nbad++;
    $display("FAIL watchdog: run=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(); sleep = 0; burst_ilv = 0; out_en_n = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1", 1'b0, ZZ);
    rst_n = 1;
    @(negedge clk);
    check("R1", 1'b0, ZZ);

    for (int i = 0; i < NV; i++) begin
      strobe_p_n = TBL[i].sp; strobe_c_n = TBL[i].sc; step_n = TBL[i].stp;
      cs_main_n = TBL[i].ea; cs_hi = TBL[i].eb; cs_lo_n = TBL[i].ec;
      wr_all_n = TBL[i].ga; wr_lane_n = TBL[i].gl; lane_n = TBL[i].ln;
      burst_ilv = TBL[i].ilv; addr = TBL[i].a; d_in = TBL[i].d;
      @(negedge clk);
      check($sformatf("%s vec %0d", TBL[i].tag, i), TBL[i].xoe, TBL[i].xq);
    end

    // R10: output enable gates the bus asynchronously
    idle();
    out_en_n = 1; #1 check("R10 oe off", 1'b0, ZZ);
    out_en_n = 0; #1 check("R10 oe on", 1'b1, B0);

    // R9: sleep blanks output and ignores a write strobe
    sleep = 1; #1 check("R9 asleep", 1'b0, ZZ);
    @(negedge clk);
    strobe_c_n = 0; wr_all_n = 0; addr = 6'd5; d_in = FF;
    repeat (2) @(negedge clk);
    check("R9 asleep held", 1'b0, ZZ);
    idle(); sleep = 0; #1 check("R9 wake", 1'b1, B0);
    @(negedge clk);
    check("R9 contents", 1'b1, B0);

    // R1: reset mid-run turns the bus off at once
    rst_n = 0; #1 check("R1 async", 1'b0, ZZ);
    @(negedge clk); rst_n = 1;
    step_n = 0;
    @(negedge clk);
    check("R1 deselected", 1'b0, ZZ);
    finish_run();
  end
endmodule